// File: doc/BRIEF.md
# NAND Page Read/Program Sequencer

This block carries out one whole page read or one whole page program on a small-page NAND device. It does not drive the device pins. Instead it sends a stream of byte-cycle requests to a separate bus cycle generator. Each request is a command latch, an address latch, a data write or a data read. A response channel returns the byte for each data read. The device's ready/busy line comes straight into the block, optionally through a synchroniser.

A host pulses `start` with a column byte, a row (page) address and the kind of operation. For a read, the block sends the setup command and the four address bytes. It then waits for the device to go busy and come back ready, and streams the page out on a valid/ready port. For a program, it sends the setup command and the address, then passes the page bytes from a valid/ready input port. It then sends the confirm command, waits out the busy period, sends the status command and reads the status byte. The status byte is reduced to a single pass/fail flag. If a busy wait runs too long, the operation stops with a timeout flag.

Top module: `nand_page_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `done`, `req_valid`, `rd_valid` and `wr_ready` are all 0.
- R2: `start` is taken only while `busy` is 0. `busy` is 1 from the cycle after an accepted start through the `done` cycle. A start pulse while `busy` is 1 causes no request at all, either during or after the running operation.
- R3: A read issues a command request with byte 0x00 when `half_sel`=0, or 0x01 when `half_sel`=1. It then issues four address requests in this order: the column byte, row bits 7:0, row bits 15:8, and row bits 23:16 zero-extended.
- R4: After the fourth read address byte, no data-read request is issued until `rb_n` has been low and then high again.
- R5: A read issues exactly PAGE_BYTES data-read requests. It presents the returned bytes on `rd_data` in the order they were returned. Each byte is held, with `rd_valid` high, until `rd_ready` takes it.
- R6: A program issues command 0x80 whatever `half_sel` is. It then issues the same four address bytes as R3, then exactly PAGE_BYTES data-write requests carrying the `wr_data` bytes in their order of acceptance, then command 0x10.
- R7: After 0x10, and once `rb_n` has gone low and returned high, a program issues command 0x70 and one data-read request. A returned byte of 0x00 gives `prog_fail`=0, and any other value gives `prog_fail`=1.
- R8: If a busy wait lasts BUSY_TIMEOUT cycles without `rb_n` completing its low-then-high sequence, the operation ends with `done` and `err_timeout`=1 and issues no further requests.
- R9: `done` is high for exactly one cycle. `prog_fail` and `err_timeout` hold their values until the next accepted start, which clears both.
- R10: `req_kind` encodes 0 as a command, 1 as an address, 2 as a data write and 3 as a data read. A command, address or data-read request keeps its kind and byte stable until `req_ready` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (taken only when idle) |
| op_prog | input | 1 | 1 = page program, 0 = page read |
| half_sel | input | 1 | For a read, start in the second half of the page |
| col_addr | input | 8 | Column byte of the address |
| row_addr | input | ROW_W | Page (row) address: page-in-block and block bits |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| prog_fail | output | 1 | Last program reported a non-zero status |
| err_timeout | output | 1 | Last operation aborted on a busy-wait timeout |
| rd_data | output | 8 | Page byte read out |
| rd_valid | output | 1 | `rd_data` is valid |
| rd_ready | input | 1 | Consumer takes `rd_data` |
| wr_data | input | 8 | Page byte to program |
| wr_valid | input | 1 | `wr_data` is valid |
| wr_ready | output | 1 | The block takes `wr_data` |
| req_valid | output | 1 | Bus cycle request valid |
| req_ready | input | 1 | Cycle generator accepts the request |
| req_kind | output | 2 | Request kind (see R10) |
| req_byte | output | 8 | Command, address or write byte |
| rsp_valid | input | 1 | Byte from a data-read cycle is valid |
| rsp_byte | input | 8 | Byte from a data-read cycle |
| rb_n | input | 1 | Device ready/busy, low while busy |

## Verification
The bench watches for a data read issued before the ready/busy low-to-high sequence completes. A sequencer that only checked for the line being high would read the page while the device was still loading it. It puts all-ones and zero addresses through the address path, so a wrong byte order or a wrong zero-extension of the top row byte shows up as a wrong address byte. It sends status values of 0x01 and 0xC0 to catch a decoder that tests only bit 0, and a stuck-busy device to catch a sequencer that would hang or keep issuing cycles. Random stalls on both handshakes, and a start pulse in the middle of an operation, catch lost or duplicated bytes and a second operation started by mistake.

// File: rtl/nps_pkg.sv
package nps_pkg;

   typedef enum logic [1:0] {
      K_CMD   = 2'd0,
      K_ADDR  = 2'd1,
      K_WDATA = 2'd2,
      K_RDATA = 2'd3
   } req_kind_t;

   localparam logic [7:0] OP_READ_LO  = 8'h00;
   localparam logic [7:0] OP_READ_HI  = 8'h01;
   localparam logic [7:0] OP_PROG     = 8'h80;
   localparam logic [7:0] OP_CONFIRM  = 8'h10;
   localparam logic [7:0] OP_STATUS   = 8'h70;
   localparam logic [7:0] STATUS_PASS = 8'h00;

   typedef enum logic [3:0] {
      S_IDLE, S_CMD1, S_ADDR, S_RWAIT, S_RREQ, S_RRSP, S_RDRAIN,
      S_WDATA, S_CMD2, S_PWAIT, S_SCMD, S_SREQ, S_SRSP, S_DONE
   } seq_state_t;

endpackage

// File: rtl/nps_addr_mux.sv
module nps_addr_mux #(
   parameter int ROW_W = 17
) (
   input  logic [7:0]       col,
   input  logic [ROW_W-1:0] row,
   input  logic [1:0]       idx,
   output logic [7:0]       abyte
);
   localparam int PAD = 24 - ROW_W;

   logic [23:0] row_x;

   generate
      if (PAD > 0) begin : g_pad
         assign row_x = {{PAD{1'b0}}, row};
      end else begin : g_nopad
         assign row_x = row[23:0];
      end
   endgenerate

   always_comb begin
      unique case (idx)
         2'd0: abyte = col;
         2'd1: abyte = row_x[7:0];
         2'd2: abyte = row_x[15:8];
         default: abyte = row_x[23:16];
      endcase
   end
endmodule

// File: rtl/nps_rb_waiter.sv
module nps_rb_waiter #(
   parameter int TIMEOUT     = 100000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   input  logic rb_n_raw,
   output logic fin,
   output logic tmo
);
   localparam int CW = $clog2(TIMEOUT + 1);

   typedef enum logic [1:0] {W_OFF, W_LOW, W_HIGH} wph_t;

   wph_t          ph;
   logic [CW-1:0] cnt;
   logic          rb;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign rb = rb_n_raw;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '1;
            else        sh <= {sh[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], rb_n_raw} & {SYNC_STAGES{1'b1}};
         end
         assign rb = sh[SYNC_STAGES-1];
      end
   endgenerate

   assign fin = (ph == W_HIGH) && rb;
   assign tmo = (ph != W_OFF) && !fin && (cnt == CW'(TIMEOUT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph  <= W_OFF;
         cnt <= '0;
      end else if (go) begin
         ph  <= W_LOW;
         cnt <= '0;
      end else if (fin || tmo) begin
         ph  <= W_OFF;
         cnt <= '0;
      end else if (ph != W_OFF) begin
         cnt <= cnt + 1'b1;
         if (ph == W_LOW && !rb) ph <= W_HIGH;
      end
   end

   AST_WAIT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      (ph != W_OFF) |-> (cnt < CW'(TIMEOUT))) else $error("wait counter overran"); // R8
endmodule

// File: rtl/nps_byte_counter.sv
module nps_byte_counter #(
   parameter int COUNT = 528
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic last
);
   localparam int CW = $clog2(COUNT);

   logic [CW-1:0] cnt;

   assign last = (cnt == CW'(COUNT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (inc) cnt <= last ? '0 : cnt + 1'b1;
   end

   AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(COUNT - 1)) else $error("byte count out of range"); // R5
endmodule

// File: rtl/nand_page_seq.sv
module nand_page_seq import nps_pkg::*; #(
   parameter int PAGE_BYTES      = 528,
   parameter int PAGES_PER_BLOCK = 32,
   parameter int NUM_BLOCKS      = 4096,
   parameter int BUSY_TIMEOUT    = 100000,
   parameter int RB_SYNC_STAGES  = 2,
   localparam int ROW_W = $clog2(PAGES_PER_BLOCK) + $clog2(NUM_BLOCKS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             op_prog,
   input  logic             half_sel,
   input  logic [7:0]       col_addr,
   input  logic [ROW_W-1:0] row_addr,
   output logic             busy,
   output logic             done,
   output logic             prog_fail,
   output logic             err_timeout,
   output logic [7:0]       rd_data,
   output logic             rd_valid,
   input  logic             rd_ready,
   input  logic [7:0]       wr_data,
   input  logic             wr_valid,
   output logic             wr_ready,
   output logic             req_valid,
   input  logic             req_ready,
   output logic [1:0]       req_kind,
   output logic [7:0]       req_byte,
   input  logic             rsp_valid,
   input  logic [7:0]       rsp_byte,
   input  logic             rb_n
);
   generate
      if (PAGE_BYTES < 2) begin : g_bad_page
         $error("PAGE_BYTES must be at least 2");
      end
      if (ROW_W > 24 || ROW_W < 1) begin : g_bad_row
         $error("row address must fit in three address bytes");
      end
      if (BUSY_TIMEOUT < 2) begin : g_bad_tmo
         $error("BUSY_TIMEOUT must be at least 2");
      end
      if (RB_SYNC_STAGES > 4) begin : g_bad_sync
         $error("RB_SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   seq_state_t       st;
   req_kind_t        kind_c;
   logic             is_prog_q, half_q;
   logic [7:0]       col_q;
   logic [ROW_W-1:0] row_q;
   logic [1:0]       aidx;
   logic [7:0]       rd_buf;
   logic             rd_full;
   logic             fail_q, tmo_q;
   logic             req_fire;
   logic [7:0]       addr_byte;
   logic             wait_go, wait_fin, wait_tmo;
   logic             cnt_clr, cnt_inc, cnt_last;

   nps_addr_mux #(.ROW_W(ROW_W)) i_amux (
      .col(col_q), .row(row_q), .idx(aidx), .abyte(addr_byte)
   );

   nps_rb_waiter #(.TIMEOUT(BUSY_TIMEOUT), .SYNC_STAGES(RB_SYNC_STAGES)) i_wait (
      .clk(clk), .rst_n(rst_n), .go(wait_go), .rb_n_raw(rb_n),
      .fin(wait_fin), .tmo(wait_tmo)
   );

   nps_byte_counter #(.COUNT(PAGE_BYTES)) i_cnt (
      .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .last(cnt_last)
   );

   // request channel decode
   always_comb begin
      req_valid = 1'b0;
      kind_c    = K_CMD;
      req_byte  = 8'h00;
      wr_ready  = 1'b0;
      unique case (st)
         S_CMD1: begin
            req_valid = 1'b1;
            req_byte  = is_prog_q ? OP_PROG : (half_q ? OP_READ_HI : OP_READ_LO);
         end
         S_ADDR: begin
            req_valid = 1'b1;
            kind_c    = K_ADDR;
            req_byte  = addr_byte;
         end
         S_RREQ: begin
            req_valid = !rd_full;
            kind_c    = K_RDATA;
         end
         S_WDATA: begin
            req_valid = wr_valid;
            kind_c    = K_WDATA;
            req_byte  = wr_data;
            wr_ready  = req_ready;
         end
         S_CMD2: begin
            req_valid = 1'b1;
            req_byte  = OP_CONFIRM;
         end
         S_SCMD: begin
            req_valid = 1'b1;
            req_byte  = OP_STATUS;
         end
         S_SREQ: begin
            req_valid = 1'b1;
            kind_c    = K_RDATA;
         end
         default: ;
      endcase
   end

   assign req_kind = kind_c;
   assign req_fire = req_valid && req_ready;
   assign wait_go  = req_fire && (((st == S_ADDR) && (aidx == 2'd3) && !is_prog_q) ||
                                  (st == S_CMD2));
   assign cnt_clr  = (st == S_IDLE);
   assign cnt_inc  = ((st == S_RRSP) && rsp_valid) || ((st == S_WDATA) && req_fire);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         is_prog_q <= 1'b0;
         half_q    <= 1'b0;
         col_q     <= '0;
         row_q     <= '0;
         aidx      <= '0;
         rd_buf    <= '0;
         rd_full   <= 1'b0;
         fail_q    <= 1'b0;
         tmo_q     <= 1'b0;
      end else begin
         if (rd_full && rd_ready) rd_full <= 1'b0;
         unique case (st)
            S_IDLE: if (start) begin
               is_prog_q <= op_prog;
               half_q    <= half_sel;
               col_q     <= col_addr;
               row_q     <= row_addr;
               aidx      <= '0;
               fail_q    <= 1'b0;
               tmo_q     <= 1'b0;
               st        <= S_CMD1;
            end
            S_CMD1: if (req_fire) st <= S_ADDR;
            S_ADDR: if (req_fire) begin
               aidx <= aidx + 1'b1;
               if (aidx == 2'd3) st <= is_prog_q ? S_WDATA : S_RWAIT;
            end
            S_RWAIT: begin
               if (wait_tmo) begin
                  tmo_q <= 1'b1;
                  st    <= S_DONE;
               end else if (wait_fin) begin
                  st <= S_RREQ;
               end
            end
            S_RREQ: if (req_fire) st <= S_RRSP;
            S_RRSP: if (rsp_valid) begin
               rd_buf  <= rsp_byte;
               rd_full <= 1'b1;
               st      <= cnt_last ? S_RDRAIN : S_RREQ;
            end
            S_RDRAIN: if (!rd_full || rd_ready) st <= S_DONE;
            S_WDATA: if (req_fire && cnt_last) st <= S_CMD2;
            S_CMD2: if (req_fire) st <= S_PWAIT;
            S_PWAIT: begin
               if (wait_tmo) begin
                  tmo_q <= 1'b1;
                  st    <= S_DONE;
               end else if (wait_fin) begin
                  st <= S_SCMD;
               end
            end
            S_SCMD: if (req_fire) st <= S_SREQ;
            S_SREQ: if (req_fire) st <= S_SRSP;
            S_SRSP: if (rsp_valid) begin
               fail_q <= (rsp_byte != STATUS_PASS);
               st     <= S_DONE;
            end
            S_DONE: st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   assign busy        = (st != S_IDLE);
   assign done        = (st == S_DONE);
   assign prog_fail   = fail_q;
   assign err_timeout = tmo_q;
   assign rd_data     = rd_buf;
   assign rd_valid    = rd_full;

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) else $error("done longer than one cycle"); // R9
   AST_DONE_UNDER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy) else $error("done without busy"); // R2
   AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start)) else $error("busy rose without start"); // R2
   AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !req_valid) else $error("request while idle"); // R2
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready && (req_kind != 2'd2)) |=>
         (req_valid && $stable(req_kind) && $stable(req_byte)))
      else $error("request changed before acceptance"); // R10
   AST_RD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)))
      else $error("read byte dropped while stalled"); // R5
   AST_TMO_ENDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_timeout) |-> done) else $error("timeout flag without done"); // R8
endmodule

// File: tb/test_nand_page_seq.sv
`timescale 1ns/100ps
module test_nand_page_seq;
   localparam int PB   = 8;
   localparam int TMO  = 40;
   localparam int ROWW = 17;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, op_prog = 1'b0, half_sel = 1'b0;
   logic [7:0] col_addr = '0;
   logic [ROWW-1:0] row_addr = '0;
   logic busy, done, prog_fail, err_timeout;
   logic [7:0] rd_data;
   logic rd_valid, rd_ready = 1'b0;
   logic [7:0] wr_data = '0;
   logic wr_valid = 1'b0, wr_ready;
   logic req_valid, req_ready = 1'b0;
   logic [1:0] req_kind;
   logic [7:0] req_byte;
   logic rsp_valid = 1'b0;
   logic [7:0] rsp_byte = '0;
   logic rb_n = 1'b1;

   int vec = 0, bad = 0, cyc = 0;
   int busy_len = 10;
   bit stuck = 0, rb_release = 0;
   logic [7:0] stat_val = 8'h00, seed = 8'h11;
   logic [1:0] lk [0:31];
   logic [7:0] lb [0:31];
   logic [7:0] rlog [0:15];
   int nlog = 0, nrd = 0, early_rd = 0, rd_k = 0, wptr = 0, wb = 0;
   int addr_run = 0, rb_lo_at = -1, rb_hi_at = -1, rsp_at = -1;
   logic [7:0] last_cmd = 8'hFF, rsp_val = '0;
   bit rb_rose = 1, wr_taken = 0;

   always #2.5 clk = ~clk;

   nand_page_seq #(.PAGE_BYTES(PB), .PAGES_PER_BLOCK(32), .NUM_BLOCKS(4096),
                   .BUSY_TIMEOUT(TMO), .RB_SYNC_STAGES(2)) i_nand_page_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .op_prog(op_prog), .half_sel(half_sel),
      .col_addr(col_addr), .row_addr(row_addr), .busy(busy), .done(done),
      .prog_fail(prog_fail), .err_timeout(err_timeout), .rd_data(rd_data),
      .rd_valid(rd_valid), .rd_ready(rd_ready), .wr_data(wr_data), .wr_valid(wr_valid),
      .wr_ready(wr_ready), .req_valid(req_valid), .req_ready(req_ready),
      .req_kind(req_kind), .req_byte(req_byte), .rsp_valid(rsp_valid),
      .rsp_byte(rsp_byte), .rb_n(rb_n));

   function automatic logic [7:0] rpat(int k);
      return 8'(k * 7 + int'(seed));
   endfunction
   function automatic logic [7:0] wpat(int k);
      return 8'(k * 13 + 1);
   endfunction
   function automatic logic [7:0] abyte(logic [7:0] c, logic [ROWW-1:0] r, int i);
      logic [23:0] rx = 24'(r);
      case (i)
         0: return c;
         1: return rx[7:0];
         2: return rx[15:8];
         default: return rx[23:16];
      endcase
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int exp);
      vec++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // device and host-side model, driven away from the rising edge
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (rb_release) begin rb_n = 1'b1; rb_release = 0; rb_rose = 1; end
         if (cyc == rb_lo_at) rb_n = 1'b0;
         if (cyc == rb_hi_at) begin rb_n = 1'b1; rb_rose = 1; end
         rsp_valid = 1'b0;
         if (cyc == rsp_at) begin rsp_valid = 1'b1; rsp_byte = rsp_val; end
         if (wr_taken) begin wr_valid = 1'b0; wptr++; wr_taken = 0; end
         if (!wr_valid && (cyc % 5) != 2) begin wr_valid = 1'b1; wr_data = wpat(wptr); end
         req_ready = (cyc % 3) != 0;
         rd_ready  = (cyc % 4) != 1;
         #1;
         if (req_valid && req_ready) begin
            if (nlog < 32) begin lk[nlog] = req_kind; lb[nlog] = req_byte; end
            nlog++;
            case (req_kind)
               2'd0: begin
                  last_cmd = req_byte; addr_run = 0;
                  if (req_byte == 8'h10) begin
                     rb_rose = 0; rb_lo_at = cyc + 2;
                     rb_hi_at = stuck ? -1 : cyc + 2 + busy_len;
                  end
               end
               2'd1: begin
                  addr_run++;
                  if (addr_run == 4 && (last_cmd == 8'h00 || last_cmd == 8'h01)) begin
                     rb_rose = 0; rb_lo_at = cyc + 2;
                     rb_hi_at = stuck ? -1 : cyc + 2 + busy_len;
                  end
               end
               2'd2: wr_taken = 1;
               default: begin
                  if (!rb_rose) early_rd++;
                  if (last_cmd == 8'h70) rsp_val = stat_val;
                  else begin rsp_val = rpat(rd_k); rd_k++; end
                  rsp_at = cyc + 2;
               end
            endcase
         end
         if (rd_valid && rd_ready) begin
            if (nrd < 16) rlog[nrd] = rd_data;
            nrd++;
         end
      end
   end

   always @(negedge clk) begin
      if (cyc > 150000) begin
         bad++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
         $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
         $finish;
      end
   end

   task automatic run_op(bit prog, bit half, logic [7:0] col, logic [ROWW-1:0] row, int ghost_at);
      int n;
      @(negedge clk); #2;
      nlog = 0; nrd = 0; early_rd = 0; rd_k = 0; wb = wptr;
      start = 1'b1; op_prog = prog; half_sel = half; col_addr = col; row_addr = row;
      @(negedge clk); #2;
      start = 1'b0; op_prog = ~prog; half_sel = ~half;
      chk(busy === 1'b1, "R2", "busy after start", busy, 1);
      chk(prog_fail === 1'b0 && err_timeout === 1'b0, "R9", "flags cleared", {prog_fail, err_timeout}, 0);
      n = 0;
      while (done !== 1'b1 && n < 3000) begin
         @(negedge clk); #2;
         n++;
         start = (ghost_at > 0 && n == ghost_at);
      end
      start = 1'b0;
      chk(n < 3000, "R2", "operation finished", n, 0);
      @(negedge clk); #2;
      chk(done === 1'b0 && busy === 1'b0, "R9", "done pulse single", {done, busy}, 0);
   endtask

   task automatic check_hdr(logic [7:0] cmd, logic [7:0] col, logic [ROWW-1:0] row, string req);
      chk(lk[0] == 2'd0 && lb[0] == cmd, req, "setup command", lb[0], cmd);
      for (int i = 0; i < 4; i++)
         chk(lk[1+i] == 2'd1 && lb[1+i] == abyte(col, row, i), req, "address byte",
             lb[1+i], abyte(col, row, i));
   endtask

   task automatic check_read(bit half, logic [7:0] col, logic [ROWW-1:0] row);
      run_op(1'b0, half, col, row, 0);
      check_hdr(half ? 8'h01 : 8'h00, col, row, "R3");
      chk(nlog == 5 + PB, "R5", "request count", nlog, 5 + PB);
      for (int i = 0; i < PB; i++) chk(lk[5+i] == 2'd3, "R5", "read request kind", lk[5+i], 3);
      chk(nrd == PB, "R5", "bytes delivered", nrd, PB);
      for (int i = 0; i < PB; i++) chk(rlog[i] == rpat(i), "R5", "read byte", rlog[i], rpat(i));
      chk(early_rd == 0, "R4", "reads before ready", early_rd, 0);
      chk(err_timeout === 1'b0, "R8", "no timeout", err_timeout, 0);
   endtask

   task automatic check_prog(bit half, logic [7:0] col, logic [ROWW-1:0] row, logic [7:0] st);
      stat_val = st;
      run_op(1'b1, half, col, row, 0);
      check_hdr(8'h80, col, row, "R6");
      chk(nlog == 8 + PB, "R6", "request count", nlog, 8 + PB);
      for (int i = 0; i < PB; i++)
         chk(lk[5+i] == 2'd2 && lb[5+i] == wpat(wb + i), "R6", "write byte", lb[5+i], wpat(wb + i));
      chk(lk[5+PB] == 2'd0 && lb[5+PB] == 8'h10, "R6", "confirm command", lb[5+PB], 8'h10);
      chk(lk[6+PB] == 2'd0 && lb[6+PB] == 8'h70, "R7", "status command", lb[6+PB], 8'h70);
      chk(lk[7+PB] == 2'd3, "R7", "status read kind", lk[7+PB], 3);
      chk(early_rd == 0, "R7", "status read before ready", early_rd, 0);
      chk(prog_fail === (st != 8'h00), "R7", "pass/fail decode", prog_fail, st != 8'h00);
   endtask

   initial begin
      #1;
      chk(busy === 1'b0 && done === 1'b0 && req_valid === 1'b0, "R1", "reset outputs",
          {busy, done, req_valid}, 0);
      chk(rd_valid === 1'b0 && wr_ready === 1'b0, "R1", "reset handshakes", {rd_valid, wr_ready}, 0);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #2;
      chk(busy === 1'b0 && req_valid === 1'b0 && rd_valid === 1'b0, "R1", "after reset",
          {busy, req_valid, rd_valid}, 0);

      // R3 R5 sweep of reads over addresses, page halves and busy lengths
      check_read(1'b0, 8'h3C, 17'h12A5B);
      check_read(1'b1, 8'hFF, 17'h1FFFF);
      check_read(1'b0, 8'h00, 17'h00000);
      for (int i = 0; i < 6; i++) begin
         busy_len = 3 + i * 4;
         seed = 8'(i * 29 + 5);
         check_read(i[0], 8'(i * 37 + 5), 17'((i * 20011 + 3) & 17'h1FFFF));
      end
      busy_len = 10;

      // R6 R7 programs, including any non-zero status as a failure
      check_prog(1'b1, 8'h00, 17'h00000, 8'h00);
      check_prog(1'b0, 8'hA5, 17'h1C3D2, 8'h01);
      // R9 flags hold after done
      repeat (10) @(negedge clk);
      #2 chk(prog_fail === 1'b1, "R9", "fail flag held", prog_fail, 1);
      check_prog(1'b0, 8'h5A, 17'h00F0F, 8'hC0);
      check_prog(1'b1, 8'h77, 17'h10001, 8'h00);

      // R2 start during an operation is ignored
      begin
         int n0;
         run_op(1'b0, 1'b0, 8'h12, 17'h00345, 6);
         n0 = nlog;
         chk(n0 == 5 + PB, "R2", "requests with ghost start", n0, 5 + PB);
         repeat (30) @(negedge clk);
         #2;
         chk(nlog == n0 && busy === 1'b0, "R2", "no second operation", nlog, n0);
      end

      // R8 stuck busy on a read and on a program
      stuck = 1;
      run_op(1'b0, 1'b0, 8'h44, 17'h00444, 0);
      chk(err_timeout === 1'b1, "R8", "read timeout flag", err_timeout, 1);
      chk(nlog == 5 && nrd == 0, "R8", "read requests after abort", nlog, 5);
      rb_release = 1;
      repeat (3) @(negedge clk);
      run_op(1'b1, 1'b0, 8'h55, 17'h00555, 0);
      chk(err_timeout === 1'b1, "R8", "program timeout flag", err_timeout, 1);
      chk(nlog == 6 + PB, "R8", "program requests after abort", nlog, 6 + PB);
      repeat (20) @(negedge clk);
      #2 chk(err_timeout === 1'b1 && nlog == 6 + PB, "R9", "timeout flag held", err_timeout, 1);
      stuck = 0;
      rb_release = 1;
      repeat (3) @(negedge clk);
      check_read(1'b1, 8'h81, 17'h0ABCD);
      chk(err_timeout === 1'b0, "R9", "timeout cleared by new start", err_timeout, 0);

      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end
endmodule